// File: doc/BRIEF.md
# Dual-Destination Command Queue Dispatcher

This block sits between a bank of command queues and two small command buffers that feed a conversion engine. Each queue shows the dispatcher its head command word, an empty flag, a trigger input and a mode bit. The mode bit selects one of two trigger styles. In edge mode a rising trigger starts a run that lasts until a control bit in a command ends it. In level mode the trigger input acts as a gate that must stay open for the run to go on. A destination bit inside each command word picks which of the two buffers the command goes to.

Each buffer has its own fixed-priority picker. In every clock, each picker takes the lowest-numbered eligible queue whose head targets its buffer, provided that buffer is not full. It pops that queue and writes the head word into the buffer in the same cycle, so both buffers can be loaded in one cycle from two different queues. A queue that is armed but empty takes no part and blocks nobody. Because priority is evaluated every cycle, a newly triggered higher-priority queue takes over a buffer from a lower one at once. Queues aimed at the other buffer have no effect on it. The dispatcher raises one-cycle status pulses when a run ends on an end-of-queue or pause command.

Top module: `qarb_dispatch`

## Requirements
- R1: After reset no queue is armed, and only a queue that is armed and not empty is ever popped. With non-empty heads and no trigger, nothing is popped or written.
- R2: A queue that is armed but empty is skipped and does not stop a lower-priority queue from being served.
- R3: Queue 0 has the highest priority and queue 5 the lowest. For each buffer, the eligible queue with the lowest index that targets it is served.
- R4: Bit 25 of a command selects its buffer: 0 sends it to buffer 0 and 1 sends it to buffer 1.
- R5: The two buffers are arbitrated independently, and both may be written in the same cycle by two different queues.
- R6: No write goes to a buffer whose full input is high. A buffer with room but no eligible queue aimed at it is not written.
- R7: A pop and its buffer write happen in the same cycle with the popped head word on that buffer's data output. Each buffer gets at most one write per cycle, and the number of pops equals the number of writes.
- R8: Sending a command with bit 31 (end of queue) set pulses that queue's end-of-queue output in the same cycle and disarms the queue from the next cycle on.
- R9: In edge mode, sending a command with bit 30 (pause) set pulses that queue's pause output in the same cycle and disarms it. The next rising edge of its trigger re-arms it. A trigger edge in the same cycle as the ending transfer is lost.
- R10: In level mode the trigger input is a gate. Its rising edge arms the queue. While it is low the queue is not served in that same cycle, and it is disarmed at the next clock. The pause bit has no effect in level mode.
- R11: A queue being served loses its buffer as soon as a higher-priority queue aimed at the same buffer is eligible. A higher-priority queue aimed at the other buffer does not stop it.
- R12: In edge mode a rising edge on a queue's trigger input arms that queue at the next clock edge, and the queue stays armed after the trigger returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_trig_i | input | NUM_Q | Per-queue trigger (edge mode) or gate (level mode) |
| q_lvl_mode_i | input | NUM_Q | Per-queue mode: 1 level, 0 edge |
| q_empty_i | input | NUM_Q | Per-queue empty flag |
| q_head_i | input | NUM_Q*CMD_W | Head command words, queue q at bits q*CMD_W upward |
| buf_full_i | input | 2 | Registered full flag of each buffer |
| q_pop_o | output | NUM_Q | Per-queue pop strobe |
| buf_wr_o | output | 2 | Per-buffer write strobe |
| buf_data_o | output | 2*CMD_W | Write data, buffer d at bits d*CMD_W upward |
| q_armed_o | output | NUM_Q | Per-queue armed (triggered) state |
| q_eoq_o | output | NUM_Q | End-of-queue pulse per queue |
| q_pause_o | output | NUM_Q | Pause pulse per queue |

## Verification
On every cycle the assertions check that no full buffer is written, that pops and writes match in number, that only armed, non-empty queues are popped, and that no eligible queue of higher priority aimed at the same buffer is passed over. They also check that both end-of-run pulses are followed by a disarmed queue. Only the bench scenarios can show the routing of each command by its select bit and the data word that reaches each buffer. The same holds for takeover by a newly armed queue, re-arming after a pause, and the gate behaviour of level mode, since these depend on sequences of trigger edges and expected values.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
   localparam int unsigned NUM_DST = 2;

   typedef enum logic [0:0] {
      PICK_SCAN = 1'b0,
      PICK_TWOS = 1'b1
   } pick_impl_e;
endpackage

// File: rtl/qarb_trig_ctl.sv
module qarb_trig_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic lvl_mode_i,
   input  logic empty_i,
   input  logic xfer_i,
   input  logic eoq_bit_i,
   input  logic pause_bit_i,
   output logic armed_o,
   output logic elig_o,
   output logic eoq_evt_o,
   output logic pause_evt_o
);
   logic trig_d;
   logic armed_q;
   logic armed_n;
   logic rise;
   logic end_eoq;
   logic end_pause;
   logic gate_shut;

   assign rise      = trig_i & ~trig_d;
   assign end_eoq   = xfer_i & eoq_bit_i;
   assign end_pause = xfer_i & pause_bit_i & ~lvl_mode_i;
   assign gate_shut = lvl_mode_i & ~trig_i;

   // ending a run wins over a trigger edge seen in the same cycle
   always_comb begin
      if (end_eoq || end_pause || gate_shut)
         armed_n = 1'b0;
      else if (rise)
         armed_n = 1'b1;
      else
         armed_n = armed_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_d  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         trig_d  <= trig_i;
         armed_q <= armed_n;
      end
   end

   assign armed_o     = armed_q;
   assign elig_o      = armed_q & ~empty_i & (~lvl_mode_i | trig_i);
   assign eoq_evt_o   = end_eoq;
   assign pause_evt_o = end_pause;
endmodule

// File: rtl/qarb_prio_pick.sv
module qarb_prio_pick #(
   parameter int unsigned         N    = 6,
   parameter qarb_pkg::pick_impl_e IMPL = qarb_pkg::PICK_SCAN
) (
   input  logic [N-1:0] req_i,
   input  logic         en_i,
   output logic [N-1:0] gnt_o
);
   logic [N-1:0] raw;

   generate
      if (IMPL == qarb_pkg::PICK_TWOS) begin : g_twos
         assign raw = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
      end else begin : g_scan
         logic found;
         always_comb begin
            raw   = '0;
            found = 1'b0;
            for (int i = 0; i < int'(N); i++) begin
               if (!found && req_i[i]) begin
                  raw[i] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign gnt_o = en_i ? raw : '0;
endmodule

// File: rtl/qarb_dispatch.sv
module qarb_dispatch #(
   parameter int unsigned          NUM_Q     = 6,
   parameter int unsigned          CMD_W     = 32,
   parameter int unsigned          SEL_BIT   = 25,
   parameter int unsigned          PAUSE_BIT = 30,
   parameter int unsigned          EOQ_BIT   = 31,
   parameter qarb_pkg::pick_impl_e PICK_IMPL = qarb_pkg::PICK_SCAN
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_Q-1:0]         q_trig_i,
   input  logic [NUM_Q-1:0]         q_lvl_mode_i,
   input  logic [NUM_Q-1:0]         q_empty_i,
   input  logic [NUM_Q*CMD_W-1:0]   q_head_i,
   input  logic [1:0]               buf_full_i,
   output logic [NUM_Q-1:0]         q_pop_o,
   output logic [1:0]               buf_wr_o,
   output logic [2*CMD_W-1:0]       buf_data_o,
   output logic [NUM_Q-1:0]         q_armed_o,
   output logic [NUM_Q-1:0]         q_eoq_o,
   output logic [NUM_Q-1:0]         q_pause_o
);
   localparam int unsigned NDST = qarb_pkg::NUM_DST;

   // elaboration-time parameter checks
   if (NUM_Q < 1) begin : g_bad_nq
      $error("NUM_Q must be at least 1");
   end
   if (SEL_BIT >= CMD_W || PAUSE_BIT >= CMD_W || EOQ_BIT >= CMD_W) begin : g_bad_pos
      $error("control bit position outside the command word");
   end
   if (SEL_BIT == PAUSE_BIT || SEL_BIT == EOQ_BIT || PAUSE_BIT == EOQ_BIT) begin : g_bad_ovl
      $error("control bit positions must differ");
   end

   logic [CMD_W-1:0] head    [NUM_Q];
   logic [NUM_Q-1:0] q_elig;
   logic [NUM_Q-1:0] q_dsel;
   logic [NUM_Q-1:0] req     [NDST];
   logic [NUM_Q-1:0] gnt     [NDST];

   generate
      for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_q
         assign head[q]   = q_head_i[q*CMD_W +: CMD_W];
         assign q_dsel[q] = head[q][SEL_BIT];

         qarb_trig_ctl u_trig (
            .clk         (clk),
            .rst_n       (rst_n),
            .trig_i      (q_trig_i[q]),
            .lvl_mode_i  (q_lvl_mode_i[q]),
            .empty_i     (q_empty_i[q]),
            .xfer_i      (q_pop_o[q]),
            .eoq_bit_i   (head[q][EOQ_BIT]),
            .pause_bit_i (head[q][PAUSE_BIT]),
            .armed_o     (q_armed_o[q]),
            .elig_o      (q_elig[q]),
            .eoq_evt_o   (q_eoq_o[q]),
            .pause_evt_o (q_pause_o[q])
         );
      end

      for (genvar d = 0; d < int'(NDST); d++) begin : g_dst
         assign req[d] = q_elig & (d == 0 ? ~q_dsel : q_dsel);

         qarb_prio_pick #(
            .N    (NUM_Q),
            .IMPL (PICK_IMPL)
         ) u_pick (
            .req_i (req[d]),
            .en_i  (~buf_full_i[d]),
            .gnt_o (gnt[d])
         );

         assign buf_wr_o[d] = |gnt[d];

         always_comb begin
            buf_data_o[d*CMD_W +: CMD_W] = '0;
            for (int q = 0; q < int'(NUM_Q); q++) begin
               buf_data_o[d*CMD_W +: CMD_W] = buf_data_o[d*CMD_W +: CMD_W]
                                            | (head[q] & {CMD_W{gnt[d][q]}});
            end
         end
      end
   endgenerate

   assign q_pop_o = gnt[0] | gnt[1];
endmodule

// File: rtl/qarb_dispatch_chk.sv
module qarb_dispatch_chk #(
   parameter int unsigned NUM_Q = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NUM_Q-1:0] q_pop_o,
   input logic [1:0]       buf_wr_o,
   input logic [1:0]       buf_full_i,
   input logic [NUM_Q-1:0] q_armed_o,
   input logic [NUM_Q-1:0] q_empty_i,
   input logic [NUM_Q-1:0] q_eoq_o,
   input logic [NUM_Q-1:0] q_pause_o,
   input logic [NUM_Q-1:0] q_elig,
   input logic [NUM_Q-1:0] q_dsel
);
   // R7
   pop_wr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(q_pop_o) == $countones(buf_wr_o));

   generate
      for (genvar d = 0; d < 2; d++) begin : g_d
         // R6
         no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            buf_wr_o[d] |-> !buf_full_i[d]);
      end

      for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_q
         // R1
         pop_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_pop_o[q] |-> (q_armed_o[q] && !q_empty_i[q]));
         // R8
         eoq_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_eoq_o[q] |=> !q_armed_o[q]);
         // R9
         pause_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_pause_o[q] |=> !q_armed_o[q]);

         for (genvar p = 0; p < q; p++) begin : g_p
            // R3
            prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !(q_pop_o[q] && q_elig[p] && (q_dsel[p] == q_dsel[q])));
         end
      end
   endgenerate
endmodule

bind qarb_dispatch qarb_dispatch_chk #(.NUM_Q(NUM_Q)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_pop_o    (q_pop_o),
   .buf_wr_o   (buf_wr_o),
   .buf_full_i (buf_full_i),
   .q_armed_o  (q_armed_o),
   .q_empty_i  (q_empty_i),
   .q_eoq_o    (q_eoq_o),
   .q_pause_o  (q_pause_o),
   .q_elig     (q_elig),
   .q_dsel     (q_dsel)
);

// File: tb/tb_qarb_dispatch.sv
`timescale 1ns/1ps
module tb_qarb_dispatch;
   localparam int NQ = 6;
   localparam int CW = 32;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NQ-1:0]   trig, lvl, empty;
   logic [NQ*CW-1:0] head;
   logic [1:0]      full;
   logic [NQ-1:0]   pop, armed, eoq, pause;
   logic [1:0]      wr;
   logic [2*CW-1:0] data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   qarb_dispatch dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .q_trig_i     (trig),
      .q_lvl_mode_i (lvl),
      .q_empty_i    (empty),
      .q_head_i     (head),
      .buf_full_i   (full),
      .q_pop_o      (pop),
      .buf_wr_o     (wr),
      .buf_data_o   (data),
      .q_armed_o    (armed),
      .q_eoq_o      (eoq),
      .q_pause_o    (pause)
   );

   // fields: {empty[5:0], sel[5:0], full[1:0], exp_pop[5:0], exp_wr[1:0]}
   localparam logic [21:0] VEC [0:9] = '{
      22'b000000_000000_00_000001_01,
      22'b000000_000001_00_000011_11,
      22'b000011_000100_00_001100_11, // R2: empty q0,q1 skipped
      22'b000000_000000_01_000000_00,
      22'b000000_111110_10_000001_01,
      22'b111111_000000_00_000000_00,
      22'b011111_100000_00_100000_10,
      22'b000000_010101_11_000000_00,
      22'b101010_000000_00_000001_01,
      22'b000001_000010_00_000110_11
   };

   function automatic logic [CW-1:0] mk(int q, logic sel, logic pz, logic eq);
      return {eq, pz, 4'b0000, sel, 25'h0000A00 + 25'(q)};
   endfunction

   task automatic set_heads(input logic [NQ-1:0] sel, input logic [NQ-1:0] pz,
                            input logic [NQ-1:0] eq);
      for (int q = 0; q < NQ; q++) head[q*CW +: CW] = mk(q, sel[q], pz[q], eq[q]);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      trig  = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_trig(input logic [NQ-1:0] t);
      @(negedge clk);
      trig = t;
      @(negedge clk);
      trig = '0;
      #1;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      lvl = '0; empty = '0; full = '0; trig = '0;
      set_heads('0, '0, '0);
      do_reset();
      #1;
      // R1: reset state, non-empty heads but nothing armed
      chk("R1 armed after reset", 64'(armed), 64'(0));
      chk("R1 pop after reset", 64'(pop), 64'(0));
      chk("R1 wr after reset", 64'(wr), 64'(0));

      // R12: arm all in edge mode
      pulse_trig('1);
      chk("R12 all armed by edge", 64'(armed), 64'h3f);

      // table walk: R3 R4 R5 R6 R7
      for (int i = 0; i < 10; i++) begin
         logic [NQ-1:0] e, s, ep;
         logic [1:0]    f, ew;
         {e, s, f, ep, ew} = VEC[i];
         @(negedge clk);
         empty = e; full = f;
         set_heads(s, '0, '0);
         #1;
         chk($sformatf("R3 R4 R5 R6 pop vec %0d", i), 64'(pop), 64'(ep));
         chk($sformatf("R6 R5 wr vec %0d", i), 64'(wr), 64'(ew));
         for (int d = 0; d < 2; d++) begin
            if (ew[d]) begin
               int wq = -1;
               for (int q = NQ - 1; q >= 0; q--)
                  if (ep[q] && (s[q] == logic'(d))) wq = q;
               chk($sformatf("R7 data buf%0d vec %0d", d, i),
                   64'(data[d*CW +: CW]), 64'(mk(wq, logic'(d), 1'b0, 1'b0)));
            end
         end
      end

      // R11: same-destination preemption only
      empty = '0; full = '0;
      set_heads(6'b000001, '0, '0);
      do_reset();
      pulse_trig(6'b001000);
      chk("R11 q3 alone", 64'(pop), 64'h08);
      pulse_trig(6'b000001);
      chk("R11 q0 other buffer keeps q3", 64'(pop), 64'h09);
      chk("R11 R5 both buffers", 64'(wr), 64'h3);
      pulse_trig(6'b000010);
      chk("R11 q1 takes buffer 0", 64'(pop), 64'h03);
      chk("R11 q3 stays armed", 64'(armed), 64'h0b);

      // R8: end of queue
      set_heads('0, '0, 6'b000100);
      empty = 6'b111011;
      do_reset();
      pulse_trig(6'b000100);
      chk("R8 eoq pop", 64'(pop), 64'h04);
      chk("R8 eoq pulse", 64'(eoq), 64'h04);
      @(negedge clk); #1;
      chk("R8 disarmed", 64'(armed), 64'h0);
      chk("R8 no pop after eoq", 64'(pop), 64'h0);
      chk("R8 pulse gone", 64'(eoq), 64'h0);

      // R9: pause in edge mode
      set_heads(6'b010000, 6'b010000, '0);
      empty = 6'b101111;
      do_reset();
      pulse_trig(6'b010000);
      chk("R9 pause pulse", 64'(pause), 64'h10);
      chk("R9 R4 write to buffer 1", 64'(wr), 64'h2);
      @(negedge clk); #1;
      chk("R9 disarmed", 64'(armed), 64'h0);
      chk("R9 no pop while paused", 64'(pop), 64'h0);
      pulse_trig(6'b010000);
      chk("R9 rearmed by edge", 64'(pop), 64'h10);

      // R10: level mode gate
      set_heads('0, 6'b000010, '0);
      empty = 6'b111101;
      lvl   = 6'b000010;
      do_reset();
      @(negedge clk);
      trig = 6'b000010;
      @(negedge clk); #1;
      chk("R10 gate arms", 64'(armed), 64'h02);
      chk("R10 pop under open gate", 64'(pop), 64'h02);
      chk("R10 pause ignored", 64'(pause), 64'h0);
      @(negedge clk); #1;
      chk("R10 still popping", 64'(pop), 64'h02);
      @(negedge clk);
      trig = '0;
      #1;
      chk("R10 gate closed blocks now", 64'(pop), 64'h0);
      @(negedge clk); #1;
      chk("R10 disarmed after close", 64'(armed), 64'h0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule